// File: doc/BRIEF.md
# Expansion ROM Base Register and Window Decoder

This block holds the expansion ROM base address register of a PCI function and decodes a 16 KB option ROM window from it. Configuration software reaches the register one byte at a time through a byte offset, read and write strobes and an 8-bit data path. The block keeps only the enable flag and the upper address bits that name a 16 KB aligned base. A memory address bus is compared against that base. A match raises a ROM select and passes the low address bits on as the offset into the ROM.

A static strap says whether a ROM is fitted. With the strap low the register does not exist: its bytes read as zero, writes to it are dropped, and the ROM select never rises. With a ROM fitted the register comes out of reset with every base bit set and the enable flag clear. Sizing software therefore reads back a window mask that shows a 16 KB window.

Top module: `exprom_bar`

## Requirements
- R1: At reset, with the strap high, bytes 0x30, 0x31, 0x32, 0x33 read 0x00, 0xC0, 0xFF, 0xFF (register 0xFFFFC000). With the strap low all four read 0x00.
- R2: A write to byte 0x30+k (k = 0..3) changes only bits 8k+7..8k of the 32-bit register.
- R3: After each write the register is masked with 0xFFFFC001. Bit 0 is the enable flag and bits 31:14 are the base. A read of byte 0x30 carries the enable flag in bit 0 with bits 7:1 zero, and byte 0x31 bits 5:0 read zero.
- R4: Writing 0xFE to byte 0x30 and 0xFF to bytes 0x31 to 0x33 reads back 0x00, 0xC0, 0xFF, 0xFF.
- R5: With the strap low, writes to bytes 0x30 to 0x33 have no effect, reads of them return 0x00, and the ROM select stays low.
- R6: Read data appears on the clock edge after the cycle in which the read strobe is high. A read of any offset outside 0x30 to 0x33 returns 0x00, and the read data is 0x00 after any cycle without a read strobe.
- R7: The ROM select is high when the enable flag is 1, the base is nonzero, and address bits 31:14 equal the base.
- R8: The ROM select is low when the enable flag is 0 or the base is zero, whatever the address.
- R9: The ROM offset output always equals address bits 13:0.
- R10: A register write changes the decode from the cycle after the write strobe. The window moves or closes with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rom_fitted | input | 1 | Static strap: a ROM is present |
| cfg_off | input | 8 | Configuration byte offset |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Configuration read byte, one clock after the strobe |
| mem_addr | input | 32 | Memory address to decode |
| rom_sel | output | 1 | Address falls in the enabled ROM window |
| rom_off | output | 14 | Offset into the ROM window |

## Verification
A wrong enable flag or base bit shows up at once on the ROM select: for addresses in the window when the enable flag or the base is wrong, or for addresses outside it when the base has moved. It also shows on the next configuration read of the affected byte. A lane write that spills into a neighbouring byte, or a mask that lets a low bit survive, appears one clock after the following read. The bench therefore reads back the register after random writes and probes addresses both matching and missing the modelled base.

// File: rtl/exprom_bar_pkg.sv
package exprom_bar_pkg;
    parameter int REG_W    = 32;
    parameter int WIN_LOG2 = 14;
    localparam int BASE_W  = REG_W - WIN_LOG2;
    parameter logic [7:0] BAR_OFF = 8'h30;

    typedef struct packed {
        logic              en;
        logic [BASE_W-1:0] base;
        logic [7:0]        rdata;
    } bar_state_t;
endpackage

// File: rtl/exprom_bar_regs.sv
module exprom_bar_regs
    import exprom_bar_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rom_fitted,
    input  logic [7:0]        cfg_off,
    input  logic              cfg_rd,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    output logic              en_o,
    output logic [BASE_W-1:0] base_o
);
    bar_state_t st_d, st_q, st_rst;
    logic [REG_W-1:0] cur_word, new_word;
    logic             hit;
    logic [1:0]       lane;

    always_comb begin
        cur_word = {st_q.base, {(WIN_LOG2-1){1'b0}}, st_q.en};
        hit      = (cfg_off[7:2] == BAR_OFF[7:2]) && rom_fitted;
        lane     = cfg_off[1:0];
        new_word = cur_word;
        new_word[{lane, 3'b000} +: 8] = cfg_wdata;

        st_d       = st_q;
        st_d.rdata = (cfg_rd && hit) ? cur_word[{lane, 3'b000} +: 8] : 8'h00;
        if (cfg_wr && hit) begin
            // mask: keep bit 0 and the base bits only
            st_d.en   = new_word[0];
            st_d.base = new_word[REG_W-1:WIN_LOG2];
        end

        st_rst       = '0;
        st_rst.base  = rom_fitted ? {BASE_W{1'b1}} : {BASE_W{1'b0}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= st_rst;
        else        st_q <= st_d;
    end

    assign cfg_rdata = st_q.rdata;
    assign en_o      = st_q.en;
    assign base_o    = st_q.base;

    // R3
    enable_byte_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_rd && cfg_off == BAR_OFF) |-> cfg_rdata[7:1] == 7'd0);
    // R6
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_rd) |-> cfg_rdata == 8'h00);
    // R10
    enable_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_wr && rom_fitted && cfg_off == BAR_OFF) |-> en_o == $past(cfg_wdata[0]));
    // R2
    top_lane_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_wr && cfg_off == BAR_OFF + 8'd3)
        |-> (en_o == $past(en_o)) && (base_o[BASE_W-9:0] == $past(base_o[BASE_W-9:0])));
endmodule

// File: rtl/exprom_bar_match.sv
module exprom_bar_match
    import exprom_bar_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [BASE_W-1:0] base_i,
    input  logic [REG_W-1:0]  addr_i,
    output logic              sel_o,
    output logic [WIN_LOG2-1:0] off_o
);
    logic live;

    always_comb begin
        live  = en_i && (base_i != '0);
        sel_o = live && (addr_i[REG_W-1:WIN_LOG2] == base_i);
        off_o = addr_i[WIN_LOG2-1:0];
    end

    // R8
    sel_needs_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_o |-> (en_i && base_i != '0));
endmodule

// File: rtl/exprom_bar.sv
module exprom_bar
    import exprom_bar_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rom_fitted,
    input  logic [7:0]  cfg_off,
    input  logic        cfg_rd,
    input  logic        cfg_wr,
    input  logic [7:0]  cfg_wdata,
    output logic [7:0]  cfg_rdata,
    input  logic [31:0] mem_addr,
    output logic        rom_sel,
    output logic [13:0] rom_off
);
    logic              en_w;
    logic [BASE_W-1:0] base_w;

    exprom_bar_regs u_regs (
        .clk(clk), .rst_n(rst_n), .rom_fitted(rom_fitted),
        .cfg_off(cfg_off), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .en_o(en_w), .base_o(base_w)
    );

    exprom_bar_match u_match (
        .clk(clk), .rst_n(rst_n), .en_i(en_w), .base_i(base_w),
        .addr_i(mem_addr), .sel_o(rom_sel), .off_o(rom_off)
    );

    // R5
    no_rom_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_fitted |-> !rom_sel);
endmodule

// File: tb/exprom_bar_test.sv
module exprom_bar_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rom_fitted = 1'b1;
    logic [7:0]  cfg_off = 8'h00;
    logic        cfg_rd = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic [31:0] mem_addr = 32'h0;
    logic        rom_sel;
    logic [13:0] rom_off;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic        m_en;
    logic [17:0] m_base;

    always #10 clk = ~clk;

    exprom_bar uut (
        .clk(clk), .rst_n(rst_n), .rom_fitted(rom_fitted),
        .cfg_off(cfg_off), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mem_addr(mem_addr), .rom_sel(rom_sel), .rom_off(rom_off)
    );

    function automatic logic [7:0] exp_byte(input logic [7:0] off);
        if (!rom_fitted) return 8'h00;
        case (off)
            8'h30: return {7'd0, m_en};
            8'h31: return {m_base[1:0], 6'd0};
            8'h32: return m_base[9:2];
            8'h33: return m_base[17:10];
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic exp_sel(input logic [31:0] a);
        return rom_fitted && m_en && (m_base != 18'd0) && (a[31:14] == m_base);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic fitted);
        @(negedge clk);
        rst_n = 1'b0; rom_fitted = fitted;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_en = 1'b0;
        m_base = fitted ? 18'h3FFFF : 18'h0;
    endtask

    task automatic cfg_write(input logic [7:0] off, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_off = off; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (rom_fitted) case (off)
            8'h30: m_en = d[0];
            8'h31: m_base[1:0] = d[7:6];
            8'h32: m_base[9:2] = d;
            8'h33: m_base[17:10] = d;
            default: ;
        endcase
    endtask

    task automatic cfg_read(input logic [7:0] off, input string req);
        logic [7:0] e;
        @(negedge clk);
        cfg_rd = 1'b1; cfg_off = off;
        e = exp_byte(off);
        @(negedge clk);
        cfg_rd = 1'b0;
        check(req, {24'd0, cfg_rdata}, {24'd0, e});
    endtask

    task automatic probe(input logic [31:0] a, input string req);
        @(negedge clk);
        mem_addr = a;
        #2;
        check(req, {31'd0, rom_sel}, {31'd0, exp_sel(a)});
        check("R9 offset", {18'd0, rom_off}, {18'd0, a[13:0]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd1234);
        do_reset(1'b1);
        // R1 reset readback
        for (int k = 0; k < 4; k++) cfg_read(8'h30 + k[7:0], "R1 reset");
        check("R1 word", {24'd0, exp_byte(8'h31)}, 32'h0000_00C0);
        probe(32'hFFFF_C010, "R8 disabled");
        // R4 sizing
        cfg_write(8'h30, 8'hFE);
        cfg_write(8'h31, 8'hFF);
        cfg_write(8'h32, 8'hFF);
        cfg_write(8'h33, 8'hFF);
        for (int k = 0; k < 4; k++) cfg_read(8'h30 + k[7:0], "R4 sizing");
        // R3 enable bit alone
        cfg_write(8'h30, 8'hFF);
        cfg_read(8'h30, "R3 enable byte");
        check("R3 literal", {24'd0, exp_byte(8'h30)}, 32'h1);
        // R7 program base 0x000D8000
        cfg_write(8'h31, 8'h80);
        cfg_write(8'h32, 8'h0D);
        cfg_write(8'h33, 8'h00);
        probe(32'h000D_8123, "R7 hit");
        check("R7 literal", {31'd0, rom_sel}, 32'd1);
        probe(32'h000D_C000, "R7 miss");
        // R2 lane isolation
        cfg_write(8'h32, 8'hA5);
        cfg_read(8'h31, "R2 lane 1 kept");
        cfg_read(8'h33, "R2 lane 3 kept");
        cfg_read(8'h30, "R2 lane 0 kept");
        cfg_write(8'h32, 8'h0D);
        // R10 decode follows write next cycle
        probe(32'h000D_8000, "R10 before");
        @(negedge clk);
        cfg_wr = 1'b1; cfg_off = 8'h30; cfg_wdata = 8'h00;
        @(negedge clk);
        cfg_wr = 1'b0; m_en = 1'b0;
        #2;
        check("R10 closed", {31'd0, rom_sel}, 32'd0);
        // R8 zero base
        cfg_write(8'h30, 8'h01);
        cfg_write(8'h31, 8'h00);
        cfg_write(8'h32, 8'h00);
        cfg_write(8'h33, 8'h00);
        probe(32'h0000_1234, "R8 zero base");
        // R6 other offsets and idle cycles
        cfg_read(8'h2C, "R6 other offset");
        cfg_read(8'h34, "R6 other offset");
        @(negedge clk);
        check("R6 idle", {24'd0, cfg_rdata}, 32'd0);
        // random phase
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            case (r[1:0])
                2'd0, 2'd1: cfg_write(8'h2E + {5'd0, r[4:2]}, r[15:8]);
                2'd2: cfg_read(8'h2E + {5'd0, r[4:2]}, "R2 R3 random read");
                default: begin
                    logic [31:0] a;
                    a = $urandom;
                    if (r[5]) a[31:14] = m_base;
                    probe(a, "R7 R8 random decode");
                end
            endcase
        end
        // R5 strap low
        do_reset(1'b0);
        for (int k = 0; k < 4; k++) cfg_read(8'h30 + k[7:0], "R1 R5 no rom");
        cfg_write(8'h30, 8'hFF);
        cfg_write(8'h33, 8'h12);
        cfg_read(8'h30, "R5 write dropped");
        cfg_read(8'h33, "R5 write dropped");
        probe(32'h1200_0000, "R5 no select");
        probe(32'h0000_0000, "R5 no select");
        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule